// File: doc/BRIEF.md
# Serial Peripheral Register Bank with Atomic Bit Aliases

This block is the bus-facing register file of a serial peripheral. It decodes a simple 32-bit register bus and holds a control word, a secondary-control word, a 9-bit baud divisor and a set of sticky error flags. The control, secondary-control and status words each own four consecutive word addresses. The first is the plain register. The other three are write-only aliases: a write to one of them clears, sets or toggles exactly the bits that are 1 in the write data, so software can change one field without a read-modify-write sequence.

The status word combines the sticky error flags with read-only mirrors of the queue fill levels and of the receive-empty indication, which are driven by the rest of the peripheral. A single data-port address reaches the queues. A bus write there pushes the write data into the transmit queue. A bus read there pops the receive queue and returns its head word. The error flags, masked by per-flag enables in the secondary-control word, drive one fault interrupt. The serial engine and the queues are outside this block.

Reads are combinational: `bus_rdata` is valid in the same cycle as `bus_re`. Writes take effect at the next clock edge. The asynchronous reset is released to the registers two clock edges after `rst_n` rises.

Top module: `sio_regbank`

## Requirements
- R1: While reset is asserted, and after it, every register (control, secondary control, baud, error flags) reads as zero, `fault_irq_o` is 0 and neither `txq_push` nor `rxq_pop` is asserted.
- R2: A write to 0x00 (control) or 0x40 (secondary control) stores all 32 bits. A read of the same address in a later cycle returns them, and `ctrl_o` / `ctrl2_o` show them from the cycle after the write.
- R3: For control (aliases 0x04/0x08/0x0C) and secondary control (0x44/0x48/0x4C), a write to the +4 alias clears, a write to the +8 alias sets and a write to the +0xC alias toggles the bits that are 1 in the write data. All other bits keep their value.
- R4: The baud register at 0x30 keeps only write-data bits 8:0. A read returns them with bits 31:9 as zero.
- R5: Status flags are receive overflow (bit 6), transmit underrun (bit 8) and frame error (bit 12). An event input sets its flag at the next edge. A flag stays set until a write of 1 to its bit at the status-clear alias 0x14. An event in the same cycle as that clear leaves the flag set. The status-set alias 0x18 may set flags. Writes to 0x10 and to the invert alias 0x1C leave the flags unchanged.
- R6: Status bits 20:16 mirror `txq_level`, bits 28:24 mirror `rxq_level` and bit 5 mirrors `rxq_empty`. No write through any status address changes them.
- R7: A write to 0x20 asserts `txq_push` for that cycle with `txq_wdata` equal to the write data. A read of 0x20 with the receive queue not empty asserts `rxq_pop` and returns `rxq_rdata`. With the queue empty, the read returns zero and does not pop.
- R8: Reads of any alias address, of reserved addresses (0x24-0x2C, 0x34-0x3C, 0x50 and above) and of any address with bits 1:0 non-zero return zero. Writes to those reserved or misaligned addresses change no register.
- R9: `fault_irq_o` is 1 exactly when an enabled flag is set. Secondary-control bit 10 enables underrun, bit 11 enables overflow and bit 12 enables frame error.
- R10: `bus_rdata` is zero in any cycle where `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_re` |
| ctrl_o | output | 32 | Control word |
| ctrl2_o | output | 32 | Secondary-control word |
| baud_o | output | 9 | Baud divisor |
| fault_irq_o | output | 1 | Fault interrupt: an enabled error flag is set |
| evt_rx_ovf | input | 1 | Receive overflow event |
| evt_tx_udr | input | 1 | Transmit underrun event |
| evt_frm_err | input | 1 | Frame error event |
| txq_level | input | 5 | Transmit queue fill level |
| rxq_level | input | 5 | Receive queue fill level |
| rxq_empty | input | 1 | Receive queue is empty |
| txq_push | output | 1 | Push strobe into the transmit queue |
| txq_wdata | output | 32 | Word pushed into the transmit queue |
| rxq_pop | output | 1 | Pop strobe from the receive queue |
| rxq_rdata | input | 32 | Head word of the receive queue |

## Verification
The hardest case to reach is a status-clear write that lands in the same cycle as the event it is meant to acknowledge. A second hard case is a misaligned address whose word bits point at a live register. The bench drives event pulses through the same per-cycle task that drives the bus, so an event and a clear can share a cycle. It also writes to 0x02 and reserved words while the control registers hold known nonzero patterns. A closing phase picks addresses, strobes, events and queue levels at random. A behavioural model checks every output on every one of those cycles, which covers overlaps the directed cases miss.

// File: rtl/sio_regbank_pkg.sv
package sio_regbank_pkg;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_CLR = 2'd1,
    OP_SET = 2'd2,
    OP_INV = 2'd3
  } alias_op_e;

  typedef enum logic [2:0] {
    T_NONE  = 3'd0,
    T_CTRL  = 3'd1,
    T_STAT  = 3'd2,
    T_DATA  = 3'd3,
    T_BAUD  = 3'd4,
    T_CTRL2 = 3'd5
  } tgt_e;

  typedef struct packed {
    tgt_e      tgt;
    alias_op_e op;
  } dec_t;

  // register groups: word address / 4
  localparam int G_CTRL  = 0;
  localparam int G_STAT  = 1;
  localparam int G_DATA  = 2;
  localparam int G_BAUD  = 3;
  localparam int G_CTRL2 = 4;

  // status bit positions
  localparam int B_RXEMPTY = 5;
  localparam int B_RXOVF   = 6;
  localparam int B_TXUDR   = 8;
  localparam int B_FRMERR  = 12;
  localparam int B_TXLVL   = 16;
  localparam int B_RXLVL   = 24;

  // secondary-control interrupt enables
  localparam int E_TXUDR  = 10;
  localparam int E_RXOVF  = 11;
  localparam int E_FRMERR = 12;

  localparam logic [31:0] FLAG_MASK =
    (32'h1 << B_RXOVF) | (32'h1 << B_TXUDR) | (32'h1 << B_FRMERR);

endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/sio_addr_dec.sv
module sio_addr_dec
  import sio_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int WW = ADDR_W - 2;
  localparam int GW = WW - 2;

  logic [GW-1:0] group;
  logic [1:0]    sub;
  logic          aligned;

  assign group   = addr[ADDR_W-1:4];
  assign sub     = addr[3:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    dec.tgt = T_NONE;
    dec.op  = alias_op_e'(sub);
    if (aligned) begin
      if (group == GW'(G_CTRL))                      dec.tgt = T_CTRL;
      else if (group == GW'(G_STAT))                 dec.tgt = T_STAT;
      else if (group == GW'(G_CTRL2))                dec.tgt = T_CTRL2;
      else if (group == GW'(G_DATA) && sub == 2'b00) dec.tgt = T_DATA;
      else if (group == GW'(G_BAUD) && sub == 2'b00) dec.tgt = T_BAUD;
    end
    if (dec.tgt == T_NONE) dec.op = OP_WR;
  end
endmodule

// File: rtl/sio_alias_reg.sv
module sio_alias_reg
  import sio_regbank_pkg::*;
#(
  parameter int           W    = 32,
  parameter logic [W-1:0] RST  = '0,
  parameter logic [W-1:0] KEEP = '1,
  parameter logic [3:0]   OPS  = 4'b1111
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  alias_op_e op,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] nxt;
  logic         sw_en;
  logic         en;

  assign sw_en = wr_en && OPS[op];
  assign en    = sw_en || (|hw_set);

  always_comb begin
    nxt = q_r;
    if (sw_en) begin
      case (op)
        OP_WR:   nxt = wdata;
        OP_CLR:  nxt = q_r & ~wdata;
        OP_SET:  nxt = q_r | wdata;
        OP_INV:  nxt = q_r ^ wdata;
        default: nxt = q_r;
      endcase
    end
    nxt = (nxt | hw_set) & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= RST;
    else if (en) q_r <= nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/sio_rd_mux.sv
module sio_rd_mux
  import sio_regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BAUD_W = 9
) (
  input  logic              re,
  input  dec_t              dec,
  input  logic [DATA_W-1:0] ctrl,
  input  logic [DATA_W-1:0] ctrl2,
  input  logic [DATA_W-1:0] status,
  input  logic [BAUD_W-1:0] baud,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              rx_empty,
  output logic [DATA_W-1:0] rdata
);
  logic plain;
  assign plain = (dec.op == OP_WR);

  always_comb begin
    rdata = '0;
    if (re && plain) begin
      case (dec.tgt)
        T_CTRL:  rdata = ctrl;
        T_STAT:  rdata = status;
        T_CTRL2: rdata = ctrl2;
        T_BAUD:  rdata = DATA_W'(baud);
        T_DATA:  rdata = rx_empty ? '0 : rx_word;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_regbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BAUD_W = 9,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] ctrl2_o,
  output logic [BAUD_W-1:0] baud_o,
  output logic              fault_irq_o,
  input  logic              evt_rx_ovf,
  input  logic              evt_tx_udr,
  input  logic              evt_frm_err,
  input  logic [LVL_W-1:0]  txq_level,
  input  logic [LVL_W-1:0]  rxq_level,
  input  logic              rxq_empty,
  output logic              txq_push,
  output logic [DATA_W-1:0] txq_wdata,
  output logic              rxq_pop,
  input  logic [DATA_W-1:0] rxq_rdata
);
  localparam logic [DATA_W-1:0] FLAGS_KEEP = DATA_W'(FLAG_MASK);

  logic rst_sync_n;
  dec_t dec;

  logic wr_ctrl, wr_ctrl2, wr_stat, wr_baud;
  logic [DATA_W-1:0] flag_hw;
  logic [DATA_W-1:0] flag_q;
  logic [DATA_W-1:0] status_word;

  sio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  assign wr_ctrl  = bus_we && (dec.tgt == T_CTRL);
  assign wr_ctrl2 = bus_we && (dec.tgt == T_CTRL2);
  assign wr_stat  = bus_we && (dec.tgt == T_STAT);
  assign wr_baud  = bus_we && (dec.tgt == T_BAUD);

  sio_alias_reg #(.W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_ctrl),
    .op     (dec.op),
    .wdata  (bus_wdata),
    .hw_set ('0),
    .q      (ctrl_o)
  );

  sio_alias_reg #(.W(DATA_W)) u_ctrl2 (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_ctrl2),
    .op     (dec.op),
    .wdata  (bus_wdata),
    .hw_set ('0),
    .q      (ctrl2_o)
  );

  sio_alias_reg #(.W(BAUD_W), .OPS(4'b0001)) u_baud (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_baud),
    .op     (dec.op),
    .wdata  (bus_wdata[BAUD_W-1:0]),
    .hw_set ('0),
    .q      (baud_o)
  );

  always_comb begin
    flag_hw           = '0;
    flag_hw[B_RXOVF]  = evt_rx_ovf;
    flag_hw[B_TXUDR]  = evt_tx_udr;
    flag_hw[B_FRMERR] = evt_frm_err;
  end

  // flags: only clear and set aliases act; events are OR-ed in after them
  sio_alias_reg #(.W(DATA_W), .KEEP(FLAGS_KEEP), .OPS(4'b0110)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_stat),
    .op     (dec.op),
    .wdata  (bus_wdata),
    .hw_set (flag_hw),
    .q      (flag_q)
  );

  always_comb begin
    status_word                          = flag_q;
    status_word[B_RXEMPTY]               = rxq_empty;
    status_word[B_TXLVL +: LVL_W]        = txq_level;
    status_word[B_RXLVL +: LVL_W]        = rxq_level;
  end

  sio_rd_mux #(.DATA_W(DATA_W), .BAUD_W(BAUD_W)) u_rd (
    .re       (bus_re),
    .dec      (dec),
    .ctrl     (ctrl_o),
    .ctrl2    (ctrl2_o),
    .status   (status_word),
    .baud     (baud_o),
    .rx_word  (rxq_rdata),
    .rx_empty (rxq_empty),
    .rdata    (bus_rdata)
  );

  assign txq_push  = bus_we && (dec.tgt == T_DATA);
  assign txq_wdata = bus_wdata;
  assign rxq_pop   = bus_re && (dec.tgt == T_DATA) && !rxq_empty;

  assign fault_irq_o = (flag_q[B_TXUDR]  && ctrl2_o[E_TXUDR])
                    || (flag_q[B_RXOVF]  && ctrl2_o[E_RXOVF])
                    || (flag_q[B_FRMERR] && ctrl2_o[E_FRMERR]);
endmodule

// File: rtl/sio_regbank_chk.sv
module sio_regbank_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              clr_ovf_bit,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [2:0]        flags,
  input logic [DATA_W-1:0] ctrl_o,
  input logic              fault_irq_o,
  input logic              evt_rx_ovf,
  input logic              rxq_empty,
  input logic              rxq_pop,
  input logic              txq_push
);
  // flags = {frame, underrun, overflow}
  logic ovf_clear;
  assign ovf_clear = bus_we && (bus_addr == ADDR_W'('h14)) && clr_ovf_bit;

  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_ovf |=> flags[0]);

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !ovf_clear) |=> flags[0]);

  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_empty |-> !rxq_pop);

  p_push_at_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txq_push |-> (bus_we && bus_addr == ADDR_W'('h20)));

  p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> (bus_rdata == '0));

  p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr[ADDR_W-1:4] == '0) |=> $stable(ctrl_o));

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq_o |-> (flags != 3'b000));
endmodule

bind sio_regbank sio_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .clr_ovf_bit (bus_wdata[sio_regbank_pkg::B_RXOVF]),
  .bus_re      (bus_re),
  .bus_rdata   (bus_rdata),
  .flags       ({flag_q[sio_regbank_pkg::B_FRMERR], flag_q[sio_regbank_pkg::B_TXUDR],
                 flag_q[sio_regbank_pkg::B_RXOVF]}),
  .ctrl_o      (ctrl_o),
  .fault_irq_o (fault_irq_o),
  .evt_rx_ovf  (evt_rx_ovf),
  .rxq_empty   (rxq_empty),
  .rxq_pop     (rxq_pop),
  .txq_push    (txq_push)
);

// File: tb/sio_regbank_bench.sv
module sio_regbank_bench;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we, bus_re;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] ctrl_o, ctrl2_o;
  logic [8:0]  baud_o;
  logic        fault_irq_o;
  logic        evt_rx_ovf, evt_tx_udr, evt_frm_err;
  logic [4:0]  txq_level, rxq_level;
  logic        rxq_empty;
  logic        txq_push, rxq_pop;
  logic [31:0] txq_wdata, rxq_rdata;

  int errors = 0;
  int checks = 0;

  // behavioural model state
  logic [31:0] m_ctrl, m_ctrl2, m_flags;
  logic [8:0]  m_baud;

  sio_regbank u_sio_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .ctrl_o(ctrl_o), .ctrl2_o(ctrl2_o), .baud_o(baud_o), .fault_irq_o(fault_irq_o),
    .evt_rx_ovf(evt_rx_ovf), .evt_tx_udr(evt_tx_udr), .evt_frm_err(evt_frm_err),
    .txq_level(txq_level), .rxq_level(rxq_level), .rxq_empty(rxq_empty),
    .txq_push(txq_push), .txq_wdata(txq_wdata), .rxq_pop(rxq_pop), .rxq_rdata(rxq_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read();
    logic [31:0] s;
    if (!bus_re) return 32'h0;
    case (bus_addr)
      8'h00: return m_ctrl;
      8'h10: begin
        s = m_flags;
        s[5] = rxq_empty;
        s[20:16] = txq_level;
        s[28:24] = rxq_level;
        return s;
      end
      8'h20: return rxq_empty ? 32'h0 : rxq_rdata;
      8'h30: return {23'h0, m_baud};
      8'h40: return m_ctrl2;
      default: return 32'h0;
    endcase
  endfunction

  // compare all outputs, then advance the model to the coming edge
  task automatic cyc(input string req);
    logic ep, epop, eirq;
    #2;
    ep   = bus_we && bus_addr == 8'h20;
    epop = bus_re && bus_addr == 8'h20 && !rxq_empty;
    eirq = (m_flags[8] && m_ctrl2[10]) || (m_flags[6] && m_ctrl2[11]) ||
           (m_flags[12] && m_ctrl2[12]);
    check(req, "rdata", bus_rdata, exp_read());
    check(req, "ctrl", ctrl_o, m_ctrl);
    check(req, "ctrl2", ctrl2_o, m_ctrl2);
    check(req, "baud", {23'h0, baud_o}, {23'h0, m_baud});
    check(req, "irq", {31'h0, fault_irq_o}, {31'h0, eirq});
    check(req, "push", {31'h0, txq_push}, {31'h0, ep});
    check(req, "pop", {31'h0, rxq_pop}, {31'h0, epop});
    if (ep) check(req, "push_data", txq_wdata, bus_wdata);
    if (!rst_n) begin
      m_ctrl = '0; m_ctrl2 = '0; m_flags = '0; m_baud = '0;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          8'h00: m_ctrl = bus_wdata;
          8'h04: m_ctrl = m_ctrl & ~bus_wdata;
          8'h08: m_ctrl = m_ctrl | bus_wdata;
          8'h0C: m_ctrl = m_ctrl ^ bus_wdata;
          8'h14: m_flags = m_flags & ~bus_wdata;
          8'h18: m_flags = m_flags | (bus_wdata & 32'h0000_1140);
          8'h30: m_baud = bus_wdata[8:0];
          8'h40: m_ctrl2 = bus_wdata;
          8'h44: m_ctrl2 = m_ctrl2 & ~bus_wdata;
          8'h48: m_ctrl2 = m_ctrl2 | bus_wdata;
          8'h4C: m_ctrl2 = m_ctrl2 ^ bus_wdata;
          default: ;
        endcase
      end
      if (evt_rx_ovf)  m_flags[6]  = 1'b1;
      if (evt_tx_udr)  m_flags[8]  = 1'b1;
      if (evt_frm_err) m_flags[12] = 1'b1;
    end
  endtask

  task automatic drive(input logic we, input logic re, input logic [7:0] a,
                       input logic [31:0] d, input logic [2:0] ev, input string req);
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
    {evt_frm_err, evt_tx_udr, evt_rx_ovf} = ev;
    cyc(req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    drive(1'b1, 1'b0, a, d, 3'b000, req);
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    drive(1'b0, 1'b1, a, 32'h0, 3'b000, req);
  endtask

  task automatic idle(input string req);
    drive(1'b0, 1'b0, 8'h00, 32'h0, 3'b000, req);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // watchdog
  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    summary();
    $finish;
  end

  localparam int NADDR = 20;
  logic [7:0] pick [NADDR] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
                               8'h20, 8'h24, 8'h30, 8'h34, 8'h40, 8'h44, 8'h48, 8'h4C,
                               8'h50, 8'h02, 8'h13, 8'hFC};

  initial begin
    rst_n = 1'b0; bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0;
    evt_rx_ovf = 0; evt_tx_udr = 0; evt_frm_err = 0;
    txq_level = 0; rxq_level = 0; rxq_empty = 1'b1; rxq_rdata = 32'h0;
    m_ctrl = '0; m_ctrl2 = '0; m_flags = '0; m_baud = '0;

    // R1: reset holds everything at zero, even under writes and events
    idle("R1");
    wr(8'h00, 32'hFFFF_FFFF, "R1");
    drive(1'b0, 1'b1, 8'h10, 32'h0, 3'b111, "R1");
    rd(8'h00, "R1");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) idle("R1");
    rd(8'h40, "R1");
    rd(8'h30, "R1");

    // R2: full-width write and read back
    wr(8'h00, 32'hA5A5_1234, "R2");
    rd(8'h00, "R2");
    wr(8'h40, 32'h0F0F_00FF, "R2");
    rd(8'h40, "R2");

    // R3: aliases
    wr(8'h08, 32'h00F0_0000, "R3");
    wr(8'h04, 32'h0000_1230, "R3");
    wr(8'h0C, 32'hFFFF_0000, "R3");
    rd(8'h00, "R3");
    wr(8'h48, 32'h8000_0000, "R3");
    wr(8'h44, 32'h0000_000F, "R3");
    wr(8'h4C, 32'h00FF_00FF, "R3");
    rd(8'h40, "R3");

    // R4: baud masking
    wr(8'h30, 32'hFFFF_FFFF, "R4");
    rd(8'h30, "R4");
    wr(8'h30, 32'h0001_2345, "R4");
    rd(8'h30, "R4");

    // R5: sticky flags
    wr(8'h40, 32'h0, "R5");
    drive(1'b0, 1'b0, 8'h00, 32'h0, 3'b001, "R5");
    idle("R5"); idle("R5");
    rd(8'h10, "R5");
    wr(8'h10, 32'h0, "R5");
    wr(8'h1C, 32'hFFFF_FFFF, "R5");
    wr(8'h14, 32'hFFFF_FEBF, "R5");
    rd(8'h10, "R5");
    wr(8'h14, 32'h0000_0040, "R5");
    rd(8'h10, "R5");
    drive(1'b1, 1'b0, 8'h14, 32'h0000_0100, 3'b010, "R5");
    rd(8'h10, "R5");
    wr(8'h18, 32'hFFFF_FFFF, "R5");
    rd(8'h10, "R5");

    // R9: interrupt enables, one by one
    wr(8'h48, 32'h0000_0400, "R9");
    wr(8'h14, 32'h0000_0100, "R9");
    wr(8'h44, 32'h0000_0400, "R9");
    wr(8'h48, 32'h0000_1000, "R9");
    wr(8'h14, 32'h0000_1000, "R9");
    wr(8'h48, 32'h0000_0800, "R9");
    wr(8'h14, 32'hFFFF_FFFF, "R9");
    drive(1'b0, 1'b0, 8'h00, 32'h0, 3'b001, "R9");
    idle("R9");
    wr(8'h14, 32'h0000_0040, "R9");
    idle("R9");

    // R6: mirrors
    txq_level = 5'h13; rxq_level = 5'h0A; rxq_empty = 1'b0;
    rd(8'h10, "R6");
    wr(8'h18, 32'hFFFF_FFFF, "R6");
    wr(8'h10, 32'h0, "R6");
    wr(8'h14, 32'hFFFF_FFFF, "R6");
    rd(8'h10, "R6");
    txq_level = 5'h1F; rxq_level = 5'h10; rxq_empty = 1'b1;
    rd(8'h10, "R6");

    // R7: data port
    wr(8'h20, 32'hDEAD_BEEF, "R7");
    rxq_empty = 1'b0; rxq_rdata = 32'hCAFE_F00D;
    rd(8'h20, "R7");
    rxq_empty = 1'b1;
    rd(8'h20, "R7");

    // R8: alias / reserved / misaligned reads and ignored writes
    rd(8'h04, "R8"); rd(8'h08, "R8"); rd(8'h0C, "R8"); rd(8'h14, "R8");
    rd(8'h18, "R8"); rd(8'h1C, "R8"); rd(8'h24, "R8"); rd(8'h2C, "R8");
    rd(8'h34, "R8"); rd(8'h3C, "R8"); rd(8'h44, "R8"); rd(8'h4C, "R8");
    rd(8'h50, "R8"); rd(8'h01, "R8"); rd(8'h42, "R8"); rd(8'hFC, "R8");
    wr(8'h00, 32'h1357_9BDF, "R8");
    wr(8'h02, 32'h0, "R8");
    wr(8'h24, 32'hFFFF_FFFF, "R8");
    wr(8'h34, 32'hFFFF_FFFF, "R8");
    wr(8'h41, 32'hFFFF_FFFF, "R8");
    wr(8'h50, 32'hFFFF_FFFF, "R8");
    rd(8'h00, "R8"); rd(8'h40, "R8"); rd(8'h30, "R8");

    // R10: no read strobe while pointing at live registers
    drive(1'b0, 1'b0, 8'h00, 32'h0, 3'b000, "R10");
    drive(1'b0, 1'b0, 8'h10, 32'h0, 3'b000, "R10");
    drive(1'b0, 1'b0, 8'h30, 32'h0, 3'b000, "R10");

    // mixed random traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [2:0] ev;
      ev = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      txq_level = 5'($urandom); rxq_level = 5'($urandom);
      rxq_empty = 1'($urandom); rxq_rdata = $urandom;
      drive(1'($urandom), 1'($urandom), pick[$urandom % NADDR], $urandom, ev, "R3 R5 R9");
    end
    idle("R5");

    summary();
    $finish;
  end
endmodule